// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block sits between a clocked request/response port and an external asynchronous static RAM of 128K words by 16 bits whose control strobes are all active low. A request carries a word address, write data, one enable bit per byte lane and a read/write flag, and it is taken on a clock edge where both valid and ready are high. The sequencer then drives chip select, write enable, output enable and one strobe per byte lane, and it holds each phase for a number of clock cycles worked out from nanosecond timing parameters and the clock period. Each count is the quotient rounded up, so any non-zero time costs at least one cycle.

Writes drive the data bus through a separate output-enable. The write overlap is held for the longest of the write-pulse, select-to-end and data-setup minimums. A recovery tail follows it, and the bus drivers are released in that tail. Reads keep output enable, chip select and the chosen lane strobes low for the longer of the address-access and output-enable-access times. The word is sampled on the last edge of that window. Lanes that were not requested come back as zero, and the data arrives with a one-cycle response pulse. A request whose lane enables are both clear is taken at once and never touches the memory. A read of that kind answers with zero.

With the default 8 ns clock, a write keeps its strobes low for 9 cycles and is followed by 1 recovery cycle. A read keeps its strobes low for 9 cycles.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held, chip select, write enable, output enable and both lane strobes are high, the data-bus drive enable is low, the response pulse is low and ready is high.
- R2: A write with at least one lane enabled holds chip select, write enable and the lane strobes low together for 9 cycles (at least 65 ns). The address and write data are driven and stable throughout, and the written bytes read back later.
- R3: Lane strobe bit 0 gates data bits 7:0 and lane strobe bit 1 gates bits 15:8. A lane strobe goes low only for a lane whose enable bit is set, and a write leaves the other byte of the word unchanged.
- R4: A read with at least one lane enabled holds chip select, output enable and the lane strobes low, with write enable high, for 9 cycles (at least 70 ns). The response pulse is high for one cycle, in the cycle right after the strobes return high.
- R5: The read response carries the memory byte for every enabled lane, sampled after the 70 ns access time has passed, and zero in every lane that was not enabled.
- R6: Ready falls in the cycle after a request with any lane enabled is accepted. It stays low for 10 cycles after a write is accepted and for 9 cycles after a read is accepted.
- R7: The bus drive enable is high only while write enable is low or during the recovery tail after it. It is never high while output enable is low, and it has been low for at least one full cycle before output enable falls.
- R8: A request with both lane enables clear is accepted with no strobe activity and ready stays high. For a read of this kind the response pulse comes in the next cycle with data zero, and a write of this kind changes no memory word.
- R9: Whenever ready is high, chip select is high and both lane strobes are high, so the memory is deselected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_o |
| mem_dq_i | input | 16 | Data read from the memory bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bc_n | output | 2 | Lane strobes, active low, bit 0 low byte |

## Verification
The strobes change on the edge that accepts a request. The memory model follows them at half-nanosecond offsets from the clock edges and measures each overlap in real time: at least 65 ns for writes and at least 70 ns for reads. The model gives valid read data only once 70 ns have passed. Ready is counted at each falling edge after acceptance and must come back after 10 cycles for a write, 9 for a read and 0 for a request with no lanes. The response pulse must be present at the same falling edge where ready returns, or at the first falling edge for a read with no lanes, and the monitor compares each pulse against the scoreboard queue at that point.

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int AW      = 17,
  parameter int DW      = 16,
  parameter int CLK_NS  = 8,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 55,
  parameter int T_SW_NS = 65,
  parameter int T_DS_NS = 30,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OA_NS = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW/8-1:0] req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW/8-1:0] mem_bc_n
);
  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NB    = DW / 8;
  localparam int WLEN  = mx(mx(cyc(T_WP_NS), cyc(T_SW_NS)), mx(cyc(T_DS_NS), 1));
  localparam int WTAIL = (cyc(T_WC_NS) > WLEN) ? cyc(T_WC_NS) - WLEN : 1;
  localparam int RLEN  = mx(mx(cyc(T_AA_NS), cyc(T_OA_NS)), 1);
  localparam int RTAIL = (cyc(T_RC_NS) > RLEN) ? cyc(T_RC_NS) - RLEN : 0;
  localparam int CMAX  = mx(mx(WLEN, WTAIL), mx(RLEN, RTAIL));
  localparam int CW    = $clog2(CMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_TAIL} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [NB-1:0] lanes;
  logic [DW-1:0] lane_mask;

  assign req_ready = (state == S_IDLE);

  always_comb
    for (int i = 0; i < NB; i++) lane_mask[i*8 +: 8] = {8{lanes[i]}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      lanes     <= '0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_bc_n  <= '1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE:
          if (req_valid) begin
            if (req_be == '0) begin
              if (!req_write) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= '0;
              end
            end else begin
              mem_addr <= req_addr;
              lanes    <= req_be;
              mem_cs_n <= 1'b0;
              mem_bc_n <= ~req_be;
              if (req_write) begin
                mem_we_n  <= 1'b0;
                mem_dq_o  <= req_wdata;
                mem_dq_oe <= 1'b1;
                cnt       <= CW'(WLEN - 1);
                state     <= S_WR;
              end else begin
                mem_oe_n <= 1'b0;
                cnt      <= CW'(RLEN - 1);
                state    <= S_RD;
              end
            end
          end
        S_WR:
          if (cnt == '0) begin
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_bc_n  <= '1;
            mem_dq_oe <= 1'b0;
            cnt       <= CW'(WTAIL - 1);
            state     <= S_TAIL;
          end else cnt <= cnt - 1'b1;
        S_RD:
          if (cnt == '0) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_dq_i & lane_mask;
            mem_cs_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_bc_n  <= '1;
            if (RTAIL == 0) state <= S_IDLE;
            else begin
              cnt   <= CW'(RTAIL - 1);
              state <= S_TAIL;
            end
          end else cnt <= cnt - 1'b1;
        default:
          if (cnt == '0) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
      endcase
    end
  end

  // R2
  write_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && (mem_bc_n != '1) && mem_dq_oe && mem_oe_n));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  // R4
  read_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n));
  // R4
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> rsp_valid);
  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_be != '0)) |=> !req_ready);
  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));
  // R7
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
  // R9
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && (mem_bc_n == '1)));
endmodule

// File: tb/sram_seq_ctrl_test.sv
`timescale 1ns/100ps
module sram_seq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid, mem_dq_oe, mem_cs_n, mem_we_n, mem_oe_n;
  logic [15:0] rsp_rdata, mem_dq_o;
  logic [15:0] mem_dq_i = 16'hBAD0;
  logic [16:0] mem_addr;
  logic [1:0]  mem_bc_n;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  sram_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_bc_n(mem_bc_n)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input logic [16:0] a);
    return {a[7:0], ~a[7:0]} ^ 16'h3C3C;
  endfunction

  // memory model (environment) and bench shadow (expectation)
  logic [15:0] mdl_mem [int];
  logic [15:0] exp_mem [int];
  function automatic logic [15:0] mdl_rd(input logic [16:0] a);
    return mdl_mem.exists(int'(a)) ? mdl_mem[int'(a)] : pat(a);
  endfunction
  function automatic logic [15:0] exp_rd(input logic [16:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : pat(a);
  endfunction

  logic [15:0] exp_q [$];
  logic [1:0]  cur_be = '0;
  int          cs_falls = 0;
  int          v_drv = 0, v_addr = 0, v_bus = 0, v_turn = 0, v_idle = 0;

  initial begin
    bit pw = 0, pr = 0, pcs = 1, poe = 1;
    realtime t_ws = 0, t_rs = 0, t_oe = -100.0;
    logic [16:0] wa = '0, ra = '0;
    #0.5;
    forever begin
      bit wn, rn;
      logic [15:0] v, t;
      #1;
      wn = !mem_cs_n && !mem_we_n && (mem_bc_n != 2'b11);
      rn = !mem_cs_n && mem_we_n && !mem_oe_n && (mem_bc_n != 2'b11);
      if (rst_n) begin
        if (pcs && !mem_cs_n) cs_falls++;
        if (wn && !pw) begin
          t_ws = $realtime; wa = mem_addr;
          chk(mem_bc_n == ~cur_be, "R3 lane strobes", {30'd0, mem_bc_n}, {30'd0, ~cur_be});
        end
        if (wn) begin
          if (!mem_dq_oe) v_drv++;
          if (mem_addr != wa) v_addr++;
          t = mdl_rd(mem_addr);
          if (!mem_bc_n[0]) t[7:0] = mem_dq_o[7:0];
          if (!mem_bc_n[1]) t[15:8] = mem_dq_o[15:8];
          mdl_mem[int'(mem_addr)] = t;
        end
        if (!wn && pw)
          chk(($realtime - t_ws) >= 65.0, "R2 write overlap ns", int'($realtime - t_ws), 65);
        if (rn && !pr) begin t_rs = $realtime; ra = mem_addr; end
        if (rn) begin
          if (mem_addr != ra) v_addr++;
          v = mdl_rd(mem_addr);
          t = 16'hA5A5;
          if (($realtime - t_rs) >= 70.0) begin
            if (!mem_bc_n[0]) t[7:0] = v[7:0];
            if (!mem_bc_n[1]) t[15:8] = v[15:8];
          end
          mem_dq_i = t;
        end else mem_dq_i = 16'hBAD0;
        if (!rn && pr)
          chk(($realtime - t_rs) >= 70.0, "R4 read overlap ns", int'($realtime - t_rs), 70);
        if (mem_dq_oe && !mem_oe_n) v_bus++;
        if (mem_dq_oe && mem_we_n && !mem_cs_n) v_bus++;
        if (mem_dq_oe) t_oe = $realtime;
        if (poe && !mem_oe_n && ($realtime - t_oe) < 8.0) v_turn++;
        if (req_ready && (!mem_cs_n || mem_bc_n != 2'b11)) v_idle++;
      end
      pw = wn; pr = rn; pcs = mem_cs_n; poe = mem_oe_n;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected response", {16'd0, rsp_rdata}, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R5 read data", {16'd0, rsp_rdata}, {16'd0, e});
      end
    end
  end

  task automatic req(input logic wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    int n;
    logic [15:0] t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be; cur_be = be;
    if (wr) begin
      t = exp_rd(a);
      if (be[0]) t[7:0] = d[7:0];
      if (be[1]) t[15:8] = d[15:8];
      exp_mem[int'(a)] = t;
    end else begin
      t = exp_rd(a);
      exp_q.push_back(t & {{8{be[1]}}, {8{be[0]}}});
    end
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!req_ready) begin n++; @(negedge clk); end
    if (be == 2'b00) begin
      chk(n == 0, "R8 ready stays high", n, 0);
      if (!wr) chk(rsp_valid, "R8 empty read response pulse", {31'd0, rsp_valid}, 1);
    end else if (wr) chk(n == 10, "R6 write busy cycles", n, 10);
    else begin
      chk(n == 9, "R6 read busy cycles", n, 9);
      chk(rsp_valid, "R4 response pulse timing", {31'd0, rsp_valid}, 1);
    end
  endtask

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    // R1
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_bc_n} == 5'b11111, "R1 strobes in reset",
        {27'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_bc_n}, 32'h1f);
    chk({mem_dq_oe, rsp_valid, req_ready} == 3'b001, "R1 oe/valid/ready in reset",
        {29'd0, mem_dq_oe, rsp_valid, req_ready}, 1);
    rst_n = 1;
    // R2 full word write and read back
    req(1, 17'h00010, 16'h1234, 2'b11);
    req(0, 17'h00010, 16'h0000, 2'b11);
    // R3 low lane only write keeps high byte
    req(1, 17'h00010, 16'hABCD, 2'b01);
    req(0, 17'h00010, 16'h0000, 2'b11);
    // R3 high lane only at top address
    req(1, 17'h1FFFF, 16'hEE11, 2'b10);
    req(0, 17'h1FFFF, 16'h0000, 2'b11);
    // R5 partial reads give zero in disabled lanes
    req(0, 17'h00010, 16'h0000, 2'b01);
    req(0, 17'h1FFFF, 16'h0000, 2'b10);
    req(0, 17'h00777, 16'h0000, 2'b11);
    // R8 empty requests
    f0 = cs_falls;
    req(1, 17'h00010, 16'hFFFF, 2'b00);
    req(0, 17'h00010, 16'h0000, 2'b00);
    chk(cs_falls == f0, "R8 no strobe activity", cs_falls, f0);
    req(0, 17'h00010, 16'h0000, 2'b11);
    // R7 write followed at once by read, several patterns
    for (int i = 0; i < 6; i++) begin
      req(1, 17'(i * 4099), 16'(16'hC3A5 ^ (i * 16'h1111)), 2'(i % 3 + 1));
      req(0, 17'(i * 4099), 16'h0000, 2'b11);
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all responses seen", exp_q.size(), 0);
    chk(v_drv == 0, "R2 data driven during write", v_drv, 0);
    chk(v_addr == 0, "R2 address stable in cycle", v_addr, 0);
    chk(v_bus == 0, "R7 bus drive only in write", v_bus, 0);
    chk(v_turn == 0, "R7 one-cycle turnaround", v_turn, 0);
    chk(v_idle == 0, "R9 deselected when ready", v_idle, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule